// File: doc/BRIEF.md
# I2C EEPROM Byte-Write Controller

This block is a single-master I2C sequencer that stores one byte into a serial EEPROM. On a request it addresses the device with a write control byte, sends a one-byte word address and the data byte, and closes the write with a stop. It then waits for the device's internal write cycle to finish. To do this it keeps sending a start and the same write control byte until the device acknowledges. Once an acknowledge arrives, it sends a start followed at once by a stop, which places the device in standby.

Both bus lines are open drain. The block pulls a line low by raising its enable output and reads the data line back through one input. It has no clock stretching, reads or arbitration. A missing acknowledge on any write byte ends the transfer with a stop and raises a sticky error flag. Polling that outlasts a millisecond-scale limit ends the same way. The limit is counted in system clock cycles, and the cycle count is derived from parameters.

Top module: `i2c_ee_bytewr`

## Requirements
- R1: After reset, and whenever the block is idle, busy, done and err are low and both scl_oe and sda_oe are low (lines released).
- R2: A write transfer is a start condition, the control byte 0xA0 (code 1010, select bits 000, write bit 0), the word address byte and then the data byte. Each byte is sent MSB first and is followed by one acknowledge bit slot in which SDA is released.
- R3: If the acknowledge of the control, address or data byte is missing (SDA high in the acknowledge slot), the block sends a stop, sets err and pulses done. No polling follows.
- R4: After the data byte is acknowledged, a stop condition is sent before the first poll starts.
- R5: Each poll is a start condition followed by the control byte 0xA0. A poll that is not acknowledged is followed by another poll.
- R6: When a poll is acknowledged, the block sends a start condition immediately followed by a stop condition, with no data bits between them, and then pulses done with err low.
- R7: Polling is abandoned at the end of the first unacknowledged poll that completes once CLK_KHZ*TIMEOUT_MS clock cycles have passed since polling began. The block then sends a stop, sets err and pulses done.
- R8: SDA changes only while SCL is low, except for the SDA edges that form start and stop conditions.
- R9: Every SCL high pulse within a transfer lasts exactly 2*QDIV clock cycles (two of the four quarters of a bit slot). The only exception is the high level that follows a stop.
- R10: A request that arrives while busy is ignored. The transfer in progress is unaffected, and no extra transfer follows it.
- R11: done is high for exactly one cycle per transfer. err holds its value until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_req | input | 1 | Request a byte write (accepted only while idle) |
| wr_addr | input | 8 | Word address within the EEPROM |
| wr_data | input | 8 | Data byte to store |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Sampled level of the SDA line |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | Sticky flag: missing acknowledge or poll timeout |

## Verification
The write frame is driven with walking-one and walking-zero data, with all-zero and all-ones data, and with alternating patterns. Addresses are derived from the data values, so a bit-order swap, a stuck bit or a mix-up between the address and data registers each produce a distinct mismatch in the captured bytes. The number of polls the modelled device refuses is swept from zero to three, which separates a controller that stops after one poll from one that repeats the poll correctly. Separate runs refuse the acknowledge at each of the three write bytes, and one run refuses every poll, so that the abort path and the timeout are each checked against computed counts of starts, stops and polls.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;
   typedef enum logic [1:0] {SL_IDLE, SL_START, SL_BIT, SL_STOP} slot_e;
   typedef enum logic [2:0] {SG_CTRL, SG_ADDR, SG_DATA, SG_WSTOP,
                             SG_POLL, SG_CONCL, SG_FIN} seg_e;
   localparam logic [7:0] CTRL_WR = 8'hA0;   // 1010 000 0
   localparam logic [3:0] ACK_BIT = 4'd8;    // ninth slot of a byte
endpackage

// File: rtl/ee_qtick.sv
module ee_qtick #(
   parameter int QDIV = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   generate
      if (QDIV == 1) begin : g_pass
         assign tick = run;
      end else begin : g_div
         localparam int DW = $clog2(QDIV);
         localparam logic [DW-1:0] LAST = DW'(QDIV - 1);
         logic [DW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt <= '0;
            else if (!run || cnt == LAST) cnt <= '0;
            else                          cnt <= cnt + 1'b1;
         end
         assign tick = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/ee_poll_timer.sv
module ee_poll_timer #(
   parameter int LIMIT = 6000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] TOP = CW'(LIMIT);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == TOP);

   // R7: once expired, the flag stays until polling stops
   p_tmr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && expired) |=> (!run || expired));
endmodule

// File: rtl/i2c_ee_bytewr.sv
module i2c_ee_bytewr
   import ee_wr_pkg::*;
#(
   parameter int CLK_KHZ    = 200000,
   parameter int TIMEOUT_MS = 30,
   parameter int QDIV       = 500
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_req,
   input  logic [7:0] wr_addr,
   input  logic [7:0] wr_data,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       sda_in,
   output logic       busy,
   output logic       done,
   output logic       err
);
   localparam int TMO_CYC = CLK_KHZ * TIMEOUT_MS;

   generate
      if (QDIV < 1 || CLK_KHZ < 1 || TIMEOUT_MS < 1) begin : g_bad_cfg
         $error("i2c_ee_bytewr: QDIV, CLK_KHZ and TIMEOUT_MS must be positive");
      end
   endgenerate

   slot_e      slot;
   seg_e       seg;
   logic [1:0] qph;
   logic [3:0] bitn;
   logic [7:0] shreg, addr_q, data_q;
   logic       ack_ok, tick, tmo, scl_hi, sda_hi;

   wire accept = wr_req && (slot == SL_IDLE);

   ee_qtick #(.QDIV(QDIV)) u_qtick (
      .clk(clk), .rst_n(rst_n), .run(slot != SL_IDLE), .tick(tick));

   ee_poll_timer #(.LIMIT(TMO_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .run((seg == SG_POLL) && (slot != SL_IDLE)), .expired(tmo));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot <= SL_IDLE;  seg <= SG_CTRL;  qph <= '0;  bitn <= '0;
         shreg <= '0;  addr_q <= '0;  data_q <= '0;
         ack_ok <= 1'b0;  done <= 1'b0;  err <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            slot <= SL_START;  seg <= SG_CTRL;  qph <= '0;  bitn <= '0;
            addr_q <= wr_addr;  data_q <= wr_data;  err <= 1'b0;
         end else if (tick) begin
            qph <= qph + 1'b1;
            if (slot == SL_BIT && bitn == ACK_BIT && qph == 2'd2)
               ack_ok <= !sda_in;
            if (qph == 2'd3) begin
               unique case (slot)
                  SL_START: begin
                     if (seg == SG_CONCL) slot <= SL_STOP;
                     else begin
                        slot <= SL_BIT;  shreg <= CTRL_WR;  bitn <= '0;
                     end
                  end
                  SL_BIT: begin
                     if (bitn != ACK_BIT) begin
                        bitn  <= bitn + 1'b1;
                        shreg <= {shreg[6:0], 1'b0};
                     end else begin
                        bitn <= '0;
                        if (!ack_ok && seg != SG_POLL) begin
                           err <= 1'b1;  seg <= SG_FIN;  slot <= SL_STOP;
                        end else begin
                           unique case (seg)
                              SG_CTRL: begin seg <= SG_ADDR;  shreg <= addr_q; end
                              SG_ADDR: begin seg <= SG_DATA;  shreg <= data_q; end
                              SG_DATA: begin seg <= SG_WSTOP; slot <= SL_STOP; end
                              SG_POLL: begin
                                 if (ack_ok) begin
                                    seg <= SG_CONCL;  slot <= SL_START;
                                 end else if (tmo) begin
                                    err <= 1'b1;  seg <= SG_FIN;  slot <= SL_STOP;
                                 end else begin
                                    slot <= SL_START;
                                 end
                              end
                              default: begin
                                 err <= 1'b1;  seg <= SG_FIN;  slot <= SL_STOP;
                              end
                           endcase
                        end
                     end
                  end
                  SL_STOP: begin
                     if (seg == SG_WSTOP) begin
                        seg <= SG_POLL;  slot <= SL_START;
                     end else begin
                        slot <= SL_IDLE;  done <= 1'b1;
                     end
                  end
                  default: slot <= SL_IDLE;
               endcase
            end
         end
      end
   end

   // Line levels per quarter: clock high in the middle two quarters
   always_comb begin
      scl_hi = 1'b1;
      sda_hi = 1'b1;
      unique case (slot)
         SL_START: begin
            scl_hi = (qph == 2'd1) || (qph == 2'd2);
            sda_hi = (qph < 2'd2);
         end
         SL_BIT: begin
            scl_hi = (qph == 2'd1) || (qph == 2'd2);
            sda_hi = (bitn == ACK_BIT) ? 1'b1 : shreg[7];
         end
         SL_STOP: begin
            scl_hi = (qph != 2'd0);
            sda_hi = (qph >= 2'd2);
         end
         default: ;
      endcase
   end

   assign scl_oe = !scl_hi;
   assign sda_oe = !sda_hi;
   assign busy   = (slot != SL_IDLE);

   p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!scl_oe && !sda_oe));

   p_sda_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (slot == SL_BIT && qph != 2'd0) |-> $stable(sda_oe));

   p_req_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_req) |=> ($stable(addr_q) && $stable(data_q)));

   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (!err && busy));
endmodule

// File: tb/i2c_ee_bytewr_test.sv
`timescale 1ns/1ps
module i2c_ee_bytewr_test;
   localparam int QD   = 2;
   localparam int KHZ  = 100;
   localparam int MS   = 3;
   localparam int LIM  = KHZ * MS;
   localparam int PCYC = 10 * 4 * QD;   // one poll: start + 9 bit slots
   localparam int NONE = 9;

   logic clk = 1'b0, rst_n = 1'b0, wr_req = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0;
   logic scl_oe, sda_oe, busy, done, err;
   logic slv_pull = 1'b0;
   wire  scl_ln = !scl_oe;
   wire  sda_ln = !(sda_oe || slv_pull);

   always #2.5 clk = ~clk;

   i2c_ee_bytewr #(.CLK_KHZ(KHZ), .TIMEOUT_MS(MS), .QDIV(QD)) uut (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_ln),
      .busy(busy), .done(done), .err(err));

   int ntot = 0, nfail = 0, cyc = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      ntot++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000) begin
         ntot++; nfail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
         $display("%0d/%0d checks passed", ntot - nfail, ntot);
         $finish;
      end
   end

   // Device model
   logic pscl = 1'b1, psda = 1'b1, in_ack = 1'b0, hi_valid = 1'b0;
   logic [7:0] sh = '0;
   logic [7:0] wb [3];
   int bitc = 0, idx = 0, txn = 0, nstart = 0, nstop = 0, npoll = 0;
   int nconcl = 0, poll_bad = 0, stops_p1 = -1, hi_w = 0, hi_bad = 0;
   int nack_at = NONE, poll_nacks = 0;

   always @(negedge clk) begin
      if (pscl && scl_ln && psda && !sda_ln) begin
         nstart++; txn++; bitc = 0; idx = 0; in_ack = 1'b0;
         if (txn == 2) stops_p1 = nstop;
      end else if (pscl && scl_ln && !psda && sda_ln) begin
         nstop++; hi_valid = 1'b0; slv_pull = 1'b0;
         if (txn >= 2 && idx == 0 && bitc <= 1) nconcl++;
      end
      if (!pscl && scl_ln) begin
         hi_w = 1; hi_valid = 1'b1;
         if (!in_ack) begin sh = {sh[6:0], sda_ln}; bitc++; end
      end else if (scl_ln) hi_w++;
      if (pscl && !scl_ln) begin
         if (hi_valid && hi_w != 2 * QD) hi_bad++;
         if (in_ack) begin
            in_ack = 1'b0; slv_pull = 1'b0; bitc = 0; idx++;
         end else if (bitc == 8) begin
            in_ack = 1'b1;
            if (txn == 1) begin
               if (idx < 3) wb[idx] = sh;
               slv_pull = (idx != nack_at);
            end else begin
               npoll++;
               if (sh != 8'hA0) poll_bad++;
               slv_pull = ((txn - 2) >= poll_nacks);
            end
         end
      end
      pscl = scl_ln; psda = sda_ln;
   end

   // mode: 0 normal, 1 inject request while busy
   task automatic do_run(input logic [7:0] a, input logic [7:0] d,
                         input int nk, input int pn, input bit inject);
      int w;
      @(posedge clk);
      nstart = 0; nstop = 0; npoll = 0; nconcl = 0; poll_bad = 0; txn = 0;
      stops_p1 = -1; hi_bad = 0; nack_at = nk; poll_nacks = pn;
      wb[0] = 8'hxx; wb[1] = 8'hxx; wb[2] = 8'hxx;
      @(negedge clk);
      wr_addr = a; wr_data = d; wr_req = 1'b1;
      @(negedge clk);
      wr_req = 1'b0;
      chk(busy === 1'b1 && err === 1'b0, "R11 err cleared on accept", err, 0);
      if (inject) begin
         repeat (30) @(negedge clk);
         wr_addr = ~a; wr_data = ~d; wr_req = 1'b1;
         @(negedge clk);
         wr_req = 1'b0;
      end
      w = 0;
      while (done !== 1'b1 && w < 6000) begin @(negedge clk); w++; end
      chk(done === 1'b1, "R11 done reached", w, 0);
      @(negedge clk);
      chk(done === 1'b0, "R11 done one cycle", done, 0);
      chk(!busy && !scl_oe && !sda_oe, "R1 idle lines released",
          {busy, scl_oe, sda_oe}, 0);
      chk(hi_bad == 0, "R9 SCL high width", hi_bad, 0);
      chk(wb[0] === 8'hA0, "R2 control byte", wb[0], 8'hA0);
   endtask

   task automatic check_ok(input logic [7:0] a, input logic [7:0] d, input int pn);
      chk(wb[1] === a, "R2 address byte MSB first", wb[1], a);
      chk(wb[2] === d, "R2 data byte MSB first", wb[2], d);
      chk(err === 1'b0, "R6 err low on success", err, 0);
      chk(stops_p1 == 1, "R4 stop before first poll", stops_p1, 1);
      chk(npoll == pn + 1, "R5 repeated polls", npoll, pn + 1);
      chk(poll_bad == 0, "R5 poll control byte", poll_bad, 0);
      chk(nconcl == 1, "R6 start then stop", nconcl, 1);
      chk(nstart == pn + 3 && nstop == 2, "R8 start/stop count",
          nstart * 100 + nstop, (pn + 3) * 100 + 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !err && !scl_oe && !sda_oe, "R1 reset state",
          {busy, done, err, scl_oe, sda_oe}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Sweep of data/address patterns and poll refusals
      for (int i = 0; i < 24; i++) begin
         logic [7:0] d, a;
         if (i < 8)       d = 8'h01 << i;
         else if (i < 16) d = ~(8'h01 << (i - 8));
         else             d = 8'(i * 37) ^ ((i[0]) ? 8'hFF : 8'h00);
         a = d ^ 8'h96;
         do_run(a, d, NONE, i % 4, 1'b0);
         check_ok(a, d, i % 4);
      end

      // R3: refusal at each write byte
      for (int k = 0; k < 3; k++) begin
         do_run(8'h3C, 8'hC3, k, 0, 1'b0);
         chk(err === 1'b1, "R3 err on missing ack", err, 1);
         chk(nstart == 1 && nstop == 1 && npoll == 0, "R3 abort without polling",
             nstart * 100 + nstop * 10 + npoll, 110);
         chk(hi_bad == 0 && nconcl == 0, "R3 no conclude", nconcl, 0);
      end

      // R7: device never finishes
      do_run(8'h55, 8'hAA, NONE, 100000, 1'b0);
      chk(err === 1'b1, "R7 err on timeout", err, 1);
      chk(npoll == (LIM + PCYC) / PCYC, "R7 poll count before timeout",
          npoll, (LIM + PCYC) / PCYC);
      chk(nstop == 2 && nconcl == 0, "R7 stop after timeout",
          nstop * 10 + nconcl, 20);
      chk(err === 1'b1, "R11 err sticky", err, 1);

      // R10: request while busy; also clears prior err (R11 inside do_run)
      do_run(8'h12, 8'h34, NONE, 1, 1'b1);
      check_ok(8'h12, 8'h34, 1);
      repeat (200) @(negedge clk);
      chk(nstart == 4 && !busy, "R10 request ignored while busy", nstart, 4);

      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
   end
endmodule